// File: doc/BRIEF.md
# Triggered Pre/Post Event Recorder

The block keeps a rolling history of protection evidence for an inverter power stage. Each time a sample strobe arrives it stores one record: DC-link average voltage with its spike flag, the phase-current peak, the lowest driver rail voltage with its undervoltage-lockout marker, the temperature and the derate level. Every record also carries a stamp from one internal free-running time counter. Records go into a circular buffer of `DEPTH` entries.

The host arms the recorder with a pre-trigger depth and a post-trigger depth. A trigger is a rising edge on any of six protection sources. Once the trigger is accepted, the recorder keeps the most recent pre-trigger records and goes on writing until the post-trigger records are in. It then freezes the buffer and holds it until the next arm. At the trigger instant it also latches an event header. The header holds a wrapping event id, the local timestamp, the set of sources that fired, the fault code, the previous protection state, the action taken and the offset from local time to the system time base. The host reads the frozen window one record at a time through an index port, oldest record first. The header and status sit on plain output ports.

Top module: `evr_event_recorder`

## Requirements
- R1: A 32-bit time counter is 0 during reset and increases by one on every clock after it. Each record stores the counter value of the cycle in which it was written. The header timestamp is the counter value of the trigger cycle.
- R2: In each cycle with `smp_valid` high, one record is written to the circular buffer of `DEPTH` entries. Writing is skipped while a captured window is held, and in an accepted-trigger cycle when the post depth is 0.
- R3: An `arm` pulse with `cfg_pre + cfg_post <= DEPTH` latches both depths, enters the armed state, clears `st_done`, `miss_cnt` and the count of samples since arming. The sample written in the arm cycle is not counted. An `arm` with a larger sum is ignored and leaves every output unchanged. When both happen in one cycle, arm wins over a trigger.
- R4: While armed, a rising edge on any bit of `trig_src` is accepted as a trigger. The bits are: 0 overvoltage, 1 overcurrent, 2 overtemperature, 3 driver fault or UVLO, 4 implausible sensor, 5 retry/latch escalation. `hdr_cause` receives exactly the bits that rose in that cycle.
- R5: The window holds min(`cfg_pre`, samples since arming) records written before the trigger cycle, followed by `cfg_post` records starting with any sample in the trigger cycle. `hdr_len` is their sum. Index 0 of `rd_idx` is the oldest record. When the last post record is written, `st_done` rises and the buffer stops changing.
- R6: `hdr_fault`, `hdr_prev` and `hdr_action` take the values of `evt_fault`, `evt_prev` and `evt_action` in the trigger cycle.
- R7: `hdr_sync_ofs` equals `sys_time` minus the local timestamp, modulo 2^32, both taken in the trigger cycle.
- R8: `hdr_id` is 0 after reset and increases by one on each accepted trigger, so the first event is 1. It wraps from 2^`EID_W`-1 to 0.
- R9: A rising trigger edge while filling or holding does not start a capture and leaves the header unchanged. It increments `miss_cnt`, which saturates at its maximum. Edges before the first arm are ignored and not counted.
- R10: `st_pre_full` is 1 when at least `cfg_pre` samples were counted since arming at the trigger, and 0 when the pre-trigger part is short.
- R11: After reset all status flags, `miss_cnt`, `hdr_id`, `hdr_len` and the other header fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one record per high cycle |
| smp_vdc_avg | input | 12 | DC-link average voltage |
| smp_vdc_pk | input | 1 | DC-link spike flag |
| smp_i_pk | input | 12 | Phase-current peak |
| smp_rail_min | input | 8 | Driver rail minimum |
| smp_uvlo | input | 1 | Driver undervoltage-lockout marker |
| smp_temp | input | 8 | Temperature |
| smp_derate | input | 3 | Derate level |
| trig_src | input | 6 | Protection trigger sources, rising-edge sensitive |
| evt_fault | input | 8 | Fault code for the header |
| evt_prev | input | 4 | Previous protection state for the header |
| evt_action | input | 4 | Action taken for the header |
| sys_time | input | 32 | System time base |
| arm | input | 1 | Arm pulse |
| cfg_pre | input | AW+1 (5) | Pre-trigger depth |
| cfg_post | input | AW+1 (5) | Post-trigger depth |
| rd_idx | input | AW (4) | Window read index |
| rd_ts | output | 32 | Record timestamp |
| rd_vdc_avg | output | 12 | Record DC-link average |
| rd_vdc_pk | output | 1 | Record spike flag |
| rd_i_pk | output | 12 | Record current peak |
| rd_rail_min | output | 8 | Record rail minimum |
| rd_uvlo | output | 1 | Record UVLO marker |
| rd_temp | output | 8 | Record temperature |
| rd_derate | output | 3 | Record derate level |
| hdr_id | output | EID_W (4) | Event id |
| hdr_ts | output | 32 | Trigger timestamp |
| hdr_cause | output | 6 | Sources that rose at the trigger |
| hdr_fault | output | 8 | Fault code |
| hdr_prev | output | 4 | Previous state |
| hdr_action | output | 4 | Action taken |
| hdr_sync_ofs | output | 32 | System-time offset |
| hdr_len | output | AW+1 (5) | Records in the window |
| st_armed | output | 1 | Waiting for a trigger |
| st_filling | output | 1 | Collecting post-trigger records |
| st_done | output | 1 | Window frozen |
| st_pre_full | output | 1 | Pre-trigger part was complete |
| miss_cnt | output | MISS_W (8) | Triggers seen while busy |

## Verification
The bench goes after the cases that only show up around the trigger instant. One is a sample that lands in the trigger cycle itself: an off-by-one design would put it in the pre part or drop it. Another is a post depth of zero with a full pre part: a design that does not suppress the trigger-cycle write would overwrite the oldest kept record. A short pre part after a fresh arm is tested too: a design that ignores the fill count would hand out stale records from before arming. Further targets are sparse strobes, which stress the post countdown; repeated triggers while filling, which a careless design would let restart the window or rewrite the header; an oversize arm request; and event-id wrap-around.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int TS_W   = 32;
  localparam int VDC_W  = 12;
  localparam int CUR_W  = 12;
  localparam int RAIL_W = 8;
  localparam int TEMP_W = 8;
  localparam int DRT_W  = 3;
  localparam int SRC_N  = 6;
  localparam int CODE_W = 8;
  localparam int PST_W  = 4;
  localparam int ACT_W  = 4;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [VDC_W-1:0]  vdc;
    logic              vdc_pk;
    logic [CUR_W-1:0]  ipk;
    logic [RAIL_W-1:0] rail;
    logic              uvlo;
    logic [TEMP_W-1:0] temp;
    logic [DRT_W-1:0]  derate;
  } rec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_FILL, ST_HOLD} cap_st_e;

  // number of pre-trigger records that can actually be kept
  function automatic int unsigned pre_take(int unsigned want, int unsigned have);
    return (have < want) ? have : want;
  endfunction

  // an arm request is legal only if the whole window fits the buffer
  function automatic logic cfg_fits(int unsigned pre, int unsigned post, int unsigned depth);
    return (pre + post) <= depth;
  endfunction

  // local-to-system time offset, modulo 2^TS_W
  function automatic logic [TS_W-1:0] sync_offset(logic [TS_W-1:0] sys_t, logic [TS_W-1:0] loc_t);
    return sys_t - loc_t;
  endfunction
endpackage

// File: rtl/evr_timebase.sv
module evr_timebase
  import evr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts == $past(ts) + 1'b1); // R1
endmodule

// File: rtl/evr_ring.sv
module evr_ring
  import evr_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  rec_t          wr_rec,
  output logic [AW-1:0] wp,
  input  logic [AW-1:0] rd_base,
  input  logic [AW-1:0] rd_idx,
  output rec_t          rd_rec
);
  rec_t          mem [DEPTH];
  logic [AW-1:0] rd_addr;

  always_ff @(posedge clk) begin
    if (we) mem[wp] <= wr_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wp <= '0;
    else if (we) wp <= wp + 1'b1;
  end

  // DEPTH is a power of two, so the AW-bit sum wraps around the ring
  assign rd_addr = rd_base + rd_idx;
  assign rd_rec  = mem[rd_addr];
endmodule

// File: rtl/evr_ctrl.sv
module evr_ctrl
  import evr_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int EID_W  = 4,
  parameter  int MISS_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              arm,
  input  logic [CW-1:0]     cfg_pre,
  input  logic [CW-1:0]     cfg_post,
  input  logic [SRC_N-1:0]  trig_src,
  input  logic [CODE_W-1:0] evt_fault,
  input  logic [PST_W-1:0]  evt_prev,
  input  logic [ACT_W-1:0]  evt_action,
  input  logic [TS_W-1:0]   sys_time,
  input  logic [TS_W-1:0]   ts,
  input  logic [AW-1:0]     wp,
  output logic              we,
  output logic [AW-1:0]     win_base,
  output logic [EID_W-1:0]  hdr_id,
  output logic [TS_W-1:0]   hdr_ts,
  output logic [SRC_N-1:0]  hdr_cause,
  output logic [CODE_W-1:0] hdr_fault,
  output logic [PST_W-1:0]  hdr_prev,
  output logic [ACT_W-1:0]  hdr_action,
  output logic [TS_W-1:0]   hdr_sync_ofs,
  output logic [CW-1:0]     hdr_len,
  output logic              st_armed,
  output logic              st_filling,
  output logic              st_done,
  output logic              st_pre_full,
  output logic [MISS_W-1:0] miss_cnt
);
  cap_st_e          st;
  logic [SRC_N-1:0] src_q, rise_bits;
  logic [CW-1:0]    pre_r, post_r, fill, left, pre_eff;
  logic             any_rise, arm_ok, accept, miss_evt;

  assign rise_bits = trig_src & ~src_q;
  assign any_rise  = |rise_bits;
  assign arm_ok    = arm && cfg_fits(int'(cfg_pre), int'(cfg_post), DEPTH);
  assign accept    = (st == ST_ARMED) && any_rise && !arm_ok;
  assign miss_evt  = ((st == ST_FILL) || (st == ST_HOLD)) && any_rise && !arm_ok;
  assign pre_eff   = CW'(pre_take(int'(pre_r), int'(fill)));
  assign we        = smp_valid && (st != ST_HOLD) && !(accept && (post_r == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  src_q <= '0;  pre_r <= '0;  post_r <= '0;
      fill <= '0;  left <= '0;  win_base <= '0;  miss_cnt <= '0;
      hdr_id <= '0;  hdr_ts <= '0;  hdr_cause <= '0;  hdr_fault <= '0;
      hdr_prev <= '0;  hdr_action <= '0;  hdr_sync_ofs <= '0;
      hdr_len <= '0;  st_pre_full <= 1'b0;
    end else begin
      src_q <= trig_src;
      if (arm_ok) begin
        st <= ST_ARMED;  pre_r <= cfg_pre;  post_r <= cfg_post;
        fill <= '0;  miss_cnt <= '0;
      end else begin
        if (miss_evt && (miss_cnt != '1)) miss_cnt <= miss_cnt + 1'b1;
        unique case (st)
          ST_ARMED: begin
            if (we && (fill != CW'(DEPTH))) fill <= fill + 1'b1;
            if (accept) begin
              win_base     <= wp - pre_eff[AW-1:0];
              hdr_len      <= pre_eff + post_r;
              st_pre_full  <= (fill >= pre_r);
              hdr_id       <= hdr_id + 1'b1;
              hdr_ts       <= ts;
              hdr_cause    <= rise_bits;
              hdr_fault    <= evt_fault;
              hdr_prev     <= evt_prev;
              hdr_action   <= evt_action;
              hdr_sync_ofs <= sync_offset(sys_time, ts);
              left         <= post_r - CW'(we);
              st <= ((post_r == '0) || (we && (post_r == CW'(1)))) ? ST_HOLD : ST_FILL;
            end
          end
          ST_FILL: begin
            if (we) begin
              left <= left - 1'b1;
              if (left == CW'(1)) st <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign st_armed   = (st == ST_ARMED);
  assign st_filling = (st == ST_FILL);
  assign st_done    = (st == ST_HOLD);

  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> hdr_id == $past(hdr_id) + 1'b1); // R8
  AST_MISS_HDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> $stable(hdr_ts) && $stable(hdr_id) && $stable(win_base)); // R9
  AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> hdr_len <= CW'(DEPTH)); // R5
  AST_IDLE_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> miss_cnt == '0); // R9
endmodule

// File: rtl/evr_event_recorder.sv
module evr_event_recorder
  import evr_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int EID_W  = 4,
  parameter  int MISS_W = 8,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [VDC_W-1:0]  smp_vdc_avg,
  input  logic              smp_vdc_pk,
  input  logic [CUR_W-1:0]  smp_i_pk,
  input  logic [RAIL_W-1:0] smp_rail_min,
  input  logic              smp_uvlo,
  input  logic [TEMP_W-1:0] smp_temp,
  input  logic [DRT_W-1:0]  smp_derate,
  input  logic [SRC_N-1:0]  trig_src,
  input  logic [CODE_W-1:0] evt_fault,
  input  logic [PST_W-1:0]  evt_prev,
  input  logic [ACT_W-1:0]  evt_action,
  input  logic [TS_W-1:0]   sys_time,
  input  logic              arm,
  input  logic [AW:0]       cfg_pre,
  input  logic [AW:0]       cfg_post,
  input  logic [AW-1:0]     rd_idx,
  output logic [TS_W-1:0]   rd_ts,
  output logic [VDC_W-1:0]  rd_vdc_avg,
  output logic              rd_vdc_pk,
  output logic [CUR_W-1:0]  rd_i_pk,
  output logic [RAIL_W-1:0] rd_rail_min,
  output logic              rd_uvlo,
  output logic [TEMP_W-1:0] rd_temp,
  output logic [DRT_W-1:0]  rd_derate,
  output logic [EID_W-1:0]  hdr_id,
  output logic [TS_W-1:0]   hdr_ts,
  output logic [SRC_N-1:0]  hdr_cause,
  output logic [CODE_W-1:0] hdr_fault,
  output logic [PST_W-1:0]  hdr_prev,
  output logic [ACT_W-1:0]  hdr_action,
  output logic [TS_W-1:0]   hdr_sync_ofs,
  output logic [AW:0]       hdr_len,
  output logic              st_armed,
  output logic              st_filling,
  output logic              st_done,
  output logic              st_pre_full,
  output logic [MISS_W-1:0] miss_cnt
);
  logic [TS_W-1:0] ts;
  logic [AW-1:0]   wp, win_base;
  logic            we;
  rec_t            wr_rec, rd_rec;

  assign wr_rec = '{ts: ts, vdc: smp_vdc_avg, vdc_pk: smp_vdc_pk, ipk: smp_i_pk,
                    rail: smp_rail_min, uvlo: smp_uvlo, temp: smp_temp, derate: smp_derate};

  evr_timebase u_tb (.clk(clk), .rst_n(rst_n), .ts(ts));

  evr_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .we(we), .wr_rec(wr_rec), .wp(wp),
    .rd_base(win_base), .rd_idx(rd_idx), .rd_rec(rd_rec));

  evr_ctrl #(.DEPTH(DEPTH), .EID_W(EID_W), .MISS_W(MISS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .arm(arm),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .trig_src(trig_src),
    .evt_fault(evt_fault), .evt_prev(evt_prev), .evt_action(evt_action),
    .sys_time(sys_time), .ts(ts), .wp(wp), .we(we), .win_base(win_base),
    .hdr_id(hdr_id), .hdr_ts(hdr_ts), .hdr_cause(hdr_cause), .hdr_fault(hdr_fault),
    .hdr_prev(hdr_prev), .hdr_action(hdr_action), .hdr_sync_ofs(hdr_sync_ofs),
    .hdr_len(hdr_len), .st_armed(st_armed), .st_filling(st_filling),
    .st_done(st_done), .st_pre_full(st_pre_full), .miss_cnt(miss_cnt));

  assign rd_ts       = rd_rec.ts;
  assign rd_vdc_avg  = rd_rec.vdc;
  assign rd_vdc_pk   = rd_rec.vdc_pk;
  assign rd_i_pk     = rd_rec.ipk;
  assign rd_rail_min = rd_rec.rail;
  assign rd_uvlo     = rd_rec.uvlo;
  assign rd_temp     = rd_rec.temp;
  assign rd_derate   = rd_rec.derate;

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> $stable(wp)); // R5
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    st_done && smp_valid |-> !we); // R2
endmodule

// File: tb/evr_event_recorder_tb_top.sv
module evr_event_recorder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int RW = 77;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 0, smp_vdc_pk = 0, smp_uvlo = 0, arm = 0;
  logic [11:0] smp_vdc_avg = 0, smp_i_pk = 0;
  logic [7:0] smp_rail_min = 0, smp_temp = 0, evt_fault = 0;
  logic [2:0] smp_derate = 0;
  logic [5:0] trig_src = 0;
  logic [3:0] evt_prev = 0, evt_action = 0, rd_idx = 0;
  logic [31:0] sys_time = 0;
  logic [4:0] cfg_pre = 0, cfg_post = 0;
  logic [31:0] rd_ts, hdr_ts, hdr_sync_ofs;
  logic [11:0] rd_vdc_avg, rd_i_pk;
  logic rd_vdc_pk, rd_uvlo, st_armed, st_filling, st_done, st_pre_full;
  logic [7:0] rd_rail_min, rd_temp, hdr_fault, miss_cnt;
  logic [2:0] rd_derate;
  logic [3:0] hdr_id, hdr_prev, hdr_action;
  logic [5:0] hdr_cause;
  logic [4:0] hdr_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  evr_event_recorder dut_i (.*);

  int n_chk = 0, n_fail = 0;
  // reference model state
  int m_st = 0, m_fill = 0, m_pre = 0, m_post = 0, m_left = 0, m_miss = 0, m_id = 0, m_len = 0;
  bit m_prefull = 0;
  logic [31:0] m_ts = 0, m_hts = 0, m_hofs = 0;
  logic [5:0] m_srcq = 0, m_hcause = 0;
  logic [7:0] m_hfault = 0;
  logic [3:0] m_hprev = 0, m_hact = 0;
  logic [RW-1:0] hist[$], win[$];

  task automatic chk(input bit ok, input string what, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at t=%0t actual=%h expected=%h", what, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk({st_armed, st_filling, st_done} == {m_st == 1, m_st == 2, m_st == 3}, "R3/R5 state flags",
        {st_armed, st_filling, st_done}, {m_st == 1, m_st == 2, m_st == 3});
    chk(miss_cnt == m_miss[7:0], "R9 miss_cnt", miss_cnt, m_miss[7:0]);
    chk(hdr_id == m_id[3:0], "R8 hdr_id", hdr_id, m_id[3:0]);
    chk(hdr_ts == m_hts, "R1 hdr_ts", hdr_ts, m_hts);
    chk(hdr_cause == m_hcause, "R4 hdr_cause", hdr_cause, m_hcause);
    chk({hdr_fault, hdr_prev, hdr_action} == {m_hfault, m_hprev, m_hact}, "R6 header codes",
        {hdr_fault, hdr_prev, hdr_action}, {m_hfault, m_hprev, m_hact});
    chk(hdr_sync_ofs == m_hofs, "R7 hdr_sync_ofs", hdr_sync_ofs, m_hofs);
    chk(hdr_len == m_len[4:0], "R5 hdr_len", hdr_len, m_len[4:0]);
    chk(st_pre_full == m_prefull, "R10 st_pre_full", st_pre_full, m_prefull);
    if (m_st == 3 && int'(rd_idx) < m_len)
      chk({rd_ts, rd_vdc_avg, rd_vdc_pk, rd_i_pk, rd_rail_min, rd_uvlo, rd_temp, rd_derate} == win[rd_idx],
          "R2/R5 window record",
          {rd_ts, rd_vdc_avg, rd_vdc_pk, rd_i_pk, rd_rail_min, rd_uvlo, rd_temp, rd_derate}, win[rd_idx]);
  endtask

  // one clock: model update from the current inputs, then edge, then compare
  task automatic step();
    logic [5:0] hit;
    bit arm_ok, acc, wr;
    int pe;
    logic [RW-1:0] rec;
    smp_vdc_avg = 12'(m_ts * 37 + 5); smp_vdc_pk = m_ts[1]; smp_i_pk = 12'(m_ts * 11);
    smp_rail_min = 8'(200 - m_ts); smp_uvlo = m_ts[2]; smp_temp = 8'(m_ts + 40);
    smp_derate = m_ts[4:2]; sys_time = m_ts >> 1;
    evt_fault = 8'(m_ts * 3); evt_prev = m_ts[3:0]; evt_action = ~m_ts[3:0];
    rec = {m_ts, smp_vdc_avg, smp_vdc_pk, smp_i_pk, smp_rail_min, smp_uvlo, smp_temp, smp_derate};
    hit = trig_src & ~m_srcq;
    arm_ok = arm && (int'(cfg_pre) + int'(cfg_post) <= DEPTH);
    acc = (m_st == 1) && (hit != 0) && !arm_ok;
    wr = smp_valid && (m_st != 3) && !(acc && m_post == 0);
    if (arm_ok) begin
      m_st = 1; m_pre = cfg_pre; m_post = cfg_post; m_fill = 0; m_miss = 0;
    end else begin
      if (hit != 0 && (m_st == 2 || m_st == 3) && m_miss < 255) m_miss++;
      if (acc) begin
        pe = (m_fill < m_pre) ? m_fill : m_pre;
        win.delete();
        for (int i = hist.size() - pe; i < hist.size(); i++) win.push_back(hist[i]);
        m_len = pe + m_post; m_prefull = (m_fill >= m_pre);
        m_hts = m_ts; m_hofs = sys_time - m_ts; m_hcause = hit;
        m_hfault = evt_fault; m_hprev = evt_prev; m_hact = evt_action;
        m_id = (m_id + 1) % 16;
        m_left = m_post;
        if (wr) begin win.push_back(rec); m_left--; end
        m_st = (m_left == 0) ? 3 : 2;
      end else if (m_st == 2 && wr) begin
        win.push_back(rec); m_left--;
        if (m_left == 0) m_st = 3;
      end else if (m_st == 1 && wr && m_fill < DEPTH) m_fill++;
    end
    if (wr) begin
      hist.push_back(rec);
      if (hist.size() > DEPTH) void'(hist.pop_front());
    end
    m_srcq = trig_src;
    @(posedge clk); #1;
    m_ts++;
    compare();
  endtask

  task automatic idle(input int n, input bit v);
    for (int i = 0; i < n; i++) begin smp_valid = v; step(); end
  endtask

  task automatic do_arm(input int pre, input int post);
    cfg_pre = 5'(pre); cfg_post = 5'(post); arm = 1; smp_valid = 1; step(); arm = 0;
  endtask

  task automatic fire(input logic [5:0] bits, input bit v);
    trig_src = bits; smp_valid = v; step(); trig_src = 0;
  endtask

  task automatic readback();
    for (int k = 0; k < m_len; k++) begin rd_idx = 4'(k); smp_valid = 1; step(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R11 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    compare(); // R11 reset state
    // R9: trigger before first arm is ignored
    fire(6'b000001, 1); idle(2, 1);
    // R4 R5 R10: full pre part, sample on the trigger cycle
    do_arm(4, 4); idle(6, 1); fire(6'b000001, 1); idle(5, 1); readback();
    // R9: triggers while filling and while holding
    do_arm(3, 6); idle(4, 1); fire(6'b000100, 1); idle(1, 1);
    fire(6'b001000, 1); idle(1, 1); fire(6'b010000, 0); idle(6, 1);
    fire(6'b100000, 1); readback();
    // R10: short pre part, sparse samples, trigger without a sample
    do_arm(6, 3); idle(2, 1); idle(2, 0); fire(6'b000110, 0);
    idle(1, 0); idle(1, 1); idle(2, 0); idle(3, 1); readback();
    // R2 R5: post depth 0 with the full buffer as pre part
    do_arm(16, 0); idle(20, 1); fire(6'b010000, 1); idle(2, 1); readback();
    // R3: oversize arm request ignored while holding
    do_arm(12, 8); idle(2, 1);
    // R3: arm wins over a simultaneous trigger edge
    do_arm(2, 2); trig_src = 6'b000001; arm = 1; smp_valid = 1; step(); arm = 0;
    trig_src = 0; idle(3, 1); fire(6'b000010, 1); idle(3, 1); readback();
    // R8: id wrap-around with single-record windows
    for (int e = 0; e < 17; e++) begin do_arm(0, 1); idle(1, 0); fire(6'b001000, 1); idle(1, 1); end
    readback();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule